// File: doc/BRIEF.md
# AAL1 Sequence-Number Correction/Detection Engine

This block inspects the one-byte AAL1 header of every received cell and decides whether its sequence number can be used. The byte carries a 4-bit sequence number (a CSI flag and a 3-bit count), a 3-bit CRC protecting those four bits, and an even-parity bit over the whole byte. Each virtual channel has its own two-state history, Correction or Detection, and its own header-error counter. How the block responds to a given mix of CRC and parity errors depends on that history.

A header enters with a channel number. One clock later the block reports a validity flag, the resulting sequence number with the CSI bit split from the count, and the channel's updated state and error count. At that same edge it writes the state and count back into a small internal per-channel table. A header for the same channel can therefore follow in the very next cycle. Later order checking of the counts, and any use of the CSI bit, belong to downstream logic.

Top module: `aal1_sn_engine`

## Requirements
- R1: A synchronous reset puts every channel into Correction state (res_state 0) with an error count of zero, and holds res_vld low.
- R2: A header presented with hdr_vld high and an in-range channel gives res_vld high exactly one cycle later, with res_chan echoing the channel. res_vld is low in every other cycle.
- R3: Header layout: bit 7 is CSI, bits 6:4 the count, bits 3:1 the remainder of SN·x^3 modulo x^3+x+1 (SN = bits 7:4), and bit 0 makes the number of ones in the byte even. In Correction state a header with neither error gives res_ok 1, the received SN, an unchanged count and Correction state.
- R4: In Correction state, a parity error with a correct CRC gives res_ok 1, the received SN, count plus one and Detection state (res_state 1).
- R5: In Correction state, a CRC error together with a parity error gives res_ok 1, count plus one and Detection state. The SN is corrected by flipping the one SN bit whose single-bit syndrome equals the received syndrome. It is passed unchanged when the syndrome matches a CRC bit position.
- R6: In Correction state, a CRC error with correct parity gives res_ok 0, the uncorrected received SN, count plus one and Detection state.
- R7: In Detection state, a header with neither error gives res_ok 1, the received SN, an unchanged count and Correction state.
- R8: In Detection state, any CRC or parity error gives res_ok 0, the uncorrected received SN, count plus one and Detection state.
- R9: res_csi carries bit 3 of the resulting SN and res_seq carries its three low bits.
- R10: Each channel's state and count change only on headers for that channel. A header for a channel in the cycle right after another header for the same channel sees the written-back context.
- R11: The error count saturates at its all-ones value and never wraps.
- R12: A header whose channel number is NUM_CH or above produces no result and changes no channel's context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_vld | input | 1 | Header present this cycle |
| hdr_chan | input | CHAN_W | Channel number of the header |
| hdr_byte | input | 8 | Received AAL1 header byte |
| res_vld | output | 1 | Result present this cycle |
| res_chan | output | CHAN_W | Channel the result belongs to |
| res_ok | output | 1 | Sequence number is trustworthy |
| res_csi | output | 1 | CSI bit of the resulting SN |
| res_seq | output | 3 | Sequence count of the resulting SN |
| res_state | output | 1 | Next state: 0 Correction, 1 Detection |
| res_errs | output | ERR_W | Updated header-error count of the channel |

## Verification
The bench aims at the corner where CRC and parity disagree. A design that mixed up the parity-only and CRC-only cases would mark uncorrectable headers valid. A wrong syndrome table would flip the wrong SN bit, or would alter the SN when only a CRC bit was hit. It sends two erroneous headers back to back on one channel; a design that read stale context would report the second as valid. It pushes one channel's counter far past all-ones, which catches a counter that wraps to zero. It also checks that headers on other channels and on out-of-range channel numbers leave a channel's history untouched.

// File: rtl/aal1_sn_pkg.sv
package aal1_sn_pkg;

   localparam int HDR_W = 8;
   localparam int SN_W  = 4;
   localparam int CRC_W = 3;
   localparam int CW_W  = SN_W + CRC_W;

   typedef enum logic {
      ST_CORR = 1'b0,
      ST_DET  = 1'b1
   } cd_state_t;

   // Remainder of x^pos modulo the generator (low CRC_W bits of the poly).
   function automatic logic [CRC_W-1:0] pos_syndrome(input int pos,
                                                     input logic [CRC_W:0] poly);
      logic [CRC_W-1:0] r;
      r = {{(CRC_W-1){1'b0}}, 1'b1};
      for (int k = 0; k < pos; k++) begin
         r = {r[CRC_W-2:0], 1'b0} ^ (r[CRC_W-1] ? poly[CRC_W-1:0] : '0);
      end
      return r;
   endfunction

endpackage

// File: rtl/aal1_hdr_check.sv
module aal1_hdr_check
   import aal1_sn_pkg::*;
#(
   parameter logic [CRC_W:0] GEN_POLY = 4'b1011
)(
   input  logic [HDR_W-1:0] hdr,
   output logic             crc_err,
   output logic             par_err,
   output logic [SN_W-1:0]  sn_rx,
   output logic [SN_W-1:0]  sn_fix
);

   if (GEN_POLY[CRC_W] != 1'b1 || GEN_POLY[0] != 1'b1) begin : g_poly_bad
      $error("aal1_hdr_check: generator needs its top and constant terms");
   end

   // Codeword = hdr[7:1]; bit i of the codeword stands for x^i.
   logic [CW_W-1:0]  cw;
   logic [CRC_W-1:0] part [CW_W];
   logic [CRC_W-1:0] syn;
   logic [SN_W-1:0]  flip;

   assign cw    = hdr[HDR_W-1:1];
   assign sn_rx = hdr[HDR_W-1:HDR_W-SN_W];

   for (genvar i = 0; i < CW_W; i++) begin : g_term
      localparam logic [CRC_W-1:0] SYN_I = pos_syndrome(i, GEN_POLY);
      assign part[i] = cw[i] ? SYN_I : '0;
   end

   always_comb begin
      syn = '0;
      for (int i = 0; i < CW_W; i++) begin
         syn = syn ^ part[i];
      end
   end

   // A syndrome that matches an SN position flips that SN bit.
   for (genvar j = 0; j < SN_W; j++) begin : g_fix
      localparam logic [CRC_W-1:0] SYN_SN = pos_syndrome(j + CRC_W, GEN_POLY);
      assign flip[j] = (syn == SYN_SN);
   end

   assign crc_err = |syn;
   assign par_err = ^hdr;
   assign sn_fix  = sn_rx ^ flip;

endmodule

// File: rtl/aal1_cd_fsm.sv
module aal1_cd_fsm
   import aal1_sn_pkg::*;
#(
   parameter int ERR_W = 8
)(
   input  cd_state_t        cur_state,
   input  logic [ERR_W-1:0] cur_errs,
   input  logic             crc_err,
   input  logic             par_err,
   input  logic [SN_W-1:0]  sn_rx,
   input  logic [SN_W-1:0]  sn_fix,
   output logic             ok,
   output logic [SN_W-1:0]  sn_out,
   output cd_state_t        nxt_state,
   output logic [ERR_W-1:0] nxt_errs
);

   if (ERR_W < 1) begin : g_width_bad
      $error("aal1_cd_fsm: ERR_W must be at least 1");
   end

   logic bump;
   logic clean;

   assign clean = !crc_err && !par_err;

   always_comb begin
      ok        = 1'b0;
      sn_out    = sn_rx;
      nxt_state = ST_DET;
      bump      = 1'b1;
      unique case (cur_state)
         ST_CORR: begin
            if (clean) begin
               ok        = 1'b1;
               nxt_state = ST_CORR;
               bump      = 1'b0;
            end else if (par_err) begin
               ok     = 1'b1;
               sn_out = crc_err ? sn_fix : sn_rx;
            end
         end
         ST_DET: begin
            if (clean) begin
               ok        = 1'b1;
               nxt_state = ST_CORR;
               bump      = 1'b0;
            end
         end
         default: ;
      endcase
   end

   always_comb begin
      if (bump && (cur_errs != '1)) nxt_errs = cur_errs + 1'b1;
      else                          nxt_errs = cur_errs;
   end

endmodule

// File: rtl/aal1_ctx_table.sv
module aal1_ctx_table
   import aal1_sn_pkg::*;
#(
   parameter int NUM_CH = 28,
   parameter int ERR_W  = 8,
   parameter int CHAN_W = 5
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [CHAN_W-1:0] rd_chan,
   output cd_state_t         rd_state,
   output logic [ERR_W-1:0]  rd_errs,
   input  logic              wr_en,
   input  logic [CHAN_W-1:0] wr_chan,
   input  cd_state_t         wr_state,
   input  logic [ERR_W-1:0]  wr_errs
);

   if (NUM_CH < 1 || NUM_CH > (1 << CHAN_W)) begin : g_depth_bad
      $error("aal1_ctx_table: NUM_CH does not fit CHAN_W");
   end

   cd_state_t        st_all [NUM_CH];
   logic [ERR_W-1:0] er_all [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      cd_state_t        st_q;
      logic [ERR_W-1:0] er_q;
      logic             hit;

      assign hit = wr_en && (wr_chan == CHAN_W'(c));

      always_ff @(posedge clk) begin
         if (rst) begin
            st_q <= ST_CORR;
            er_q <= '0;
         end else if (hit) begin
            st_q <= wr_state;
            er_q <= wr_errs;
         end
      end

      assign st_all[c] = st_q;
      assign er_all[c] = er_q;
   end

   always_comb begin
      rd_state = ST_CORR;
      rd_errs  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_chan == CHAN_W'(c)) begin
            rd_state = st_all[c];
            rd_errs  = er_all[c];
         end
      end
   end

endmodule

// File: rtl/aal1_sn_engine.sv
module aal1_sn_engine
   import aal1_sn_pkg::*;
#(
   parameter int               NUM_CH   = 28,
   parameter int               ERR_W    = 8,
   parameter int               CHAN_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   parameter logic [CRC_W:0]   GEN_POLY = 4'b1011
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              hdr_vld,
   input  logic [CHAN_W-1:0] hdr_chan,
   input  logic [7:0]        hdr_byte,
   output logic              res_vld,
   output logic [CHAN_W-1:0] res_chan,
   output logic              res_ok,
   output logic              res_csi,
   output logic [2:0]        res_seq,
   output logic              res_state,
   output logic [ERR_W-1:0]  res_errs
);

   localparam int CHAN_PAD = 32 - CHAN_W;

   if (CHAN_W < 1 || CHAN_W > 16) begin : g_chan_bad
      $error("aal1_sn_engine: CHAN_W out of range");
   end

   logic             in_range;
   logic             take;
   cd_state_t        cur_state;
   logic [ERR_W-1:0] cur_errs;
   logic             crc_err;
   logic             par_err;
   logic [SN_W-1:0]  sn_rx;
   logic [SN_W-1:0]  sn_fix;
   logic             ok_d;
   logic [SN_W-1:0]  sn_d;
   cd_state_t        st_d;
   logic [ERR_W-1:0] errs_d;

   assign in_range = ({{CHAN_PAD{1'b0}}, hdr_chan} < NUM_CH);
   assign take     = hdr_vld && in_range;

   aal1_ctx_table #(
      .NUM_CH (NUM_CH),
      .ERR_W  (ERR_W),
      .CHAN_W (CHAN_W)
   ) u_ctx (
      .clk      (clk),
      .rst      (rst),
      .rd_chan  (hdr_chan),
      .rd_state (cur_state),
      .rd_errs  (cur_errs),
      .wr_en    (take),
      .wr_chan  (hdr_chan),
      .wr_state (st_d),
      .wr_errs  (errs_d)
   );

   aal1_hdr_check #(
      .GEN_POLY (GEN_POLY)
   ) u_chk_hdr (
      .hdr     (hdr_byte),
      .crc_err (crc_err),
      .par_err (par_err),
      .sn_rx   (sn_rx),
      .sn_fix  (sn_fix)
   );

   aal1_cd_fsm #(
      .ERR_W (ERR_W)
   ) u_fsm (
      .cur_state (cur_state),
      .cur_errs  (cur_errs),
      .crc_err   (crc_err),
      .par_err   (par_err),
      .sn_rx     (sn_rx),
      .sn_fix    (sn_fix),
      .ok        (ok_d),
      .sn_out    (sn_d),
      .nxt_state (st_d),
      .nxt_errs  (errs_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_vld <= 1'b0;
      end else begin
         res_vld <= take;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         res_chan  <= hdr_chan;
         res_ok    <= ok_d;
         res_csi   <= sn_d[SN_W-1];
         res_seq   <= sn_d[SN_W-2:0];
         res_state <= st_d;
         res_errs  <= errs_d;
      end
   end

endmodule

// File: rtl/aal1_sn_engine_chk.sv
module aal1_sn_engine_chk #(
   parameter int NUM_CH = 28,
   parameter int ERR_W  = 8,
   parameter int CHAN_W = 5
)(
   input logic              clk,
   input logic              rst,
   input logic              hdr_vld,
   input logic [CHAN_W-1:0] hdr_chan,
   input logic [7:0]        hdr_byte,
   input logic              res_vld,
   input logic [CHAN_W-1:0] res_chan,
   input logic              res_ok,
   input logic              res_csi,
   input logic [2:0]        res_seq,
   input logic              res_state,
   input logic [ERR_W-1:0]  res_errs
);

   logic hdr_in_range;
   assign hdr_in_range = ({{(32-CHAN_W){1'b0}}, hdr_chan} < NUM_CH);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !res_vld);

   // R2
   resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (res_vld == $past(hdr_vld && hdr_in_range)));

   // R2
   resp_chan_chk: assert property (@(posedge clk) disable iff (rst)
      (res_vld && !$past(rst)) |-> (res_chan == $past(hdr_chan)));

   // R6
   bad_goes_det_chk: assert property (@(posedge clk) disable iff (rst)
      (res_vld && !res_ok) |-> res_state);

   // R7
   corr_is_ok_chk: assert property (@(posedge clk) disable iff (rst)
      (res_vld && !res_state) |-> res_ok);

   // R8
   raw_sn_on_bad_chk: assert property (@(posedge clk) disable iff (rst)
      (res_vld && !res_ok && !$past(rst)) |-> ({res_csi, res_seq} == $past(hdr_byte[7:4])));

   // R4
   det_counted_chk: assert property (@(posedge clk) disable iff (rst)
      (res_vld && res_state) |-> (res_errs != '0));

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (res_vld && !res_ok) |-> (res_errs != '0));

endmodule

bind aal1_sn_engine aal1_sn_engine_chk #(
   .NUM_CH (NUM_CH),
   .ERR_W  (ERR_W),
   .CHAN_W (CHAN_W)
) u_sva (.*);

// File: tb/sim_aal1_sn_engine.sv
`timescale 1ns/1ps
module sim_aal1_sn_engine;

   localparam int NUM_CH = 28;
   localparam int ERR_W  = 8;
   localparam int CHAN_W = 5;
   localparam int NVEC   = 14;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              hdr_vld = 1'b0;
   logic [CHAN_W-1:0] hdr_chan = '0;
   logic [7:0]        hdr_byte = '0;
   logic              res_vld;
   logic [CHAN_W-1:0] res_chan;
   logic              res_ok;
   logic              res_csi;
   logic [2:0]        res_seq;
   logic              res_state;
   logic [ERR_W-1:0]  res_errs;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   int m_state [NUM_CH];
   int m_errs  [NUM_CH];
   bit e_ok;
   int e_st;
   int e_er;
   logic [3:0] e_sn;

   always #2.5 clk = ~clk;

   aal1_sn_engine #(.NUM_CH(NUM_CH), .ERR_W(ERR_W), .CHAN_W(CHAN_W)) u0 (
      .clk(clk), .rst(rst), .hdr_vld(hdr_vld), .hdr_chan(hdr_chan),
      .hdr_byte(hdr_byte), .res_vld(res_vld), .res_chan(res_chan),
      .res_ok(res_ok), .res_csi(res_csi), .res_seq(res_seq),
      .res_state(res_state), .res_errs(res_errs));

   // {chan, byte, expected ok, expected next state}
   localparam logic [14:0] VEC [NVEC] = '{
      {5'd0,  8'h59, 1'b1, 1'b0},   // R3 clean in Correction
      {5'd0,  8'h58, 1'b1, 1'b1},   // R4 parity only
      {5'd0,  8'hA6, 1'b1, 1'b0},   // R7 clean in Detection
      {5'd0,  8'hD9, 1'b1, 1'b1},   // R5 SN bit 3 hit, corrected
      {5'd0,  8'hC6, 1'b0, 1'b1},   // R8 CRC only in Detection
      {5'd0,  8'h00, 1'b1, 1'b0},   // R7
      {5'd0,  8'h06, 1'b0, 1'b1},   // R6 CRC only in Correction
      {5'd1,  8'hFF, 1'b1, 1'b0},   // R10 other channel fresh
      {5'd1,  8'hFD, 1'b1, 1'b1},   // R5 syndrome in CRC field
      {5'd0,  8'h3B, 1'b0, 1'b1},   // R8 parity only in Detection
      {5'd1,  8'h3A, 1'b1, 1'b0},   // R7
      {5'd0,  8'h3A, 1'b1, 1'b0},   // R7
      {5'd2,  8'h49, 1'b1, 1'b1},   // R5 SN bit 0 hit
      {5'd27, 8'hA6, 1'b1, 1'b0}    // R10 last channel
   };

   function automatic logic [2:0] crc3(input logic [3:0] sn);
      logic [2:0] r = 3'b000;
      for (int b = 3; b >= 0; b--) begin
         logic fb = sn[b] ^ r[2];
         r = {r[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
      end
      return r;
   endfunction

   task automatic model(input int ch, input logic [7:0] by);
      logic [3:0] sn  = by[7:4];
      bit crc_bad     = (crc3(sn) != by[3:1]);
      bit par_bad     = ^by;
      bit clean       = !crc_bad && !par_bad;
      e_sn = sn;
      if (clean) begin
         e_ok = 1'b1; e_st = 0; e_er = m_errs[ch];
      end else begin
         e_st = 1;
         e_er = (m_errs[ch] < 255) ? m_errs[ch] + 1 : 255;
         e_ok = (m_state[ch] == 0) && par_bad;
         if (m_state[ch] == 0 && par_bad && crc_bad) begin
            for (int j = 0; j < 4; j++) begin
               if (crc3(sn ^ (4'b1 << j)) == by[3:1]) e_sn = sn ^ (4'b1 << j);
            end
         end
      end
      m_state[ch] = e_st;
      m_errs[ch]  = e_er;
   endtask

   task automatic chk(input bit good, input string tag, input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_res(input int ch, input string tag);
      chk(res_vld === 1'b1, {tag, " R2 vld"}, int'(res_vld), 1);
      chk(res_chan == CHAN_W'(ch), {tag, " R2 chan"}, int'(res_chan), ch);
      chk(res_ok == e_ok, {tag, " ok"}, int'(res_ok), int'(e_ok));
      chk({res_csi, res_seq} == e_sn, {tag, " R9 sn"}, int'({res_csi, res_seq}), int'(e_sn));
      chk(int'(res_state) == e_st, {tag, " state"}, int'(res_state), e_st);
      chk(int'(res_errs) == e_er, {tag, " count"}, int'(res_errs), e_er);
   endtask

   task automatic send(input int ch, input logic [7:0] by, input string tag);
      @(negedge clk);
      hdr_vld = 1'b1; hdr_chan = CHAN_W'(ch); hdr_byte = by;
      model(ch, by);
      @(negedge clk);
      hdr_vld = 1'b0;
      check_res(ch, tag);
      @(negedge clk);
      chk(res_vld === 1'b0, {tag, " R2 idle"}, int'(res_vld), 0);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         m_state[c] = 0;
         m_errs[c]  = 0;
      end
   endtask

   initial begin
      do_reset();
      chk(res_vld === 1'b0, "R1 reset vld", int'(res_vld), 0);

      for (int i = 0; i < NVEC; i++) begin
         int ch = int'(VEC[i][14:10]);
         send(ch, VEC[i][9:2], $sformatf("vec%0d", i));
         chk(res_ok == VEC[i][1], "R3 table ok", int'(res_ok), int'(VEC[i][1]));
         chk(res_state == VEC[i][0], "R3 table state", int'(res_state), int'(VEC[i][0]));
      end

      // R10 back-to-back headers on one channel
      @(negedge clk);
      hdr_vld = 1'b1; hdr_chan = 5'd3; hdr_byte = 8'h58;
      model(3, 8'h58);
      @(negedge clk);
      check_res(3, "R10 first");
      hdr_byte = 8'h58;
      model(3, 8'h58);
      @(negedge clk);
      hdr_vld = 1'b0;
      check_res(3, "R10 second");

      // R12 out-of-range channel: no result, channel 0 untouched
      @(negedge clk);
      hdr_vld = 1'b1; hdr_chan = 5'd30; hdr_byte = 8'h06;
      @(negedge clk);
      hdr_vld = 1'b0;
      chk(res_vld === 1'b0, "R12 no result", int'(res_vld), 0);
      send(0, 8'h59, "R12 ch0 unchanged");

      // R11 saturation on channel 4
      for (int k = 1; k <= 260; k++) begin
         send(4, 8'h58, "R11 sat");
         if (k == 255 || k == 260)
            chk(int'(res_errs) == 255, "R11 held at max", int'(res_errs), 255);
      end

      // R1 reset clears context
      do_reset();
      chk(res_vld === 1'b0, "R1 vld after reset", int'(res_vld), 0);
      send(4, 8'h59, "R1 ch4");
      send(0, 8'h58, "R1 ch0");

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule